// File: doc/BRIEF.md
# Bus Port Halt Handshake Controller

This controller quiesces a single bus master port before its power domain is switched off. A one-cycle start pulse begins a halt sequence. If the port already reports idle, the sequence completes at once and no halt request is raised. If the port is busy, the controller raises a halt request and waits for the port's acknowledge. It looks at the acknowledge only at fixed poll intervals, and it gives up after a bounded number of polls.

After an acknowledge or a timeout, the controller samples the port's idle status a final time and drops the halt request. It then pulses done for one cycle. The failure flag in that cycle shows whether the port failed to reach idle. Dropping the request does not release the port, which stays halted until its own reset. Both port status inputs pass through a register chain before the controller uses them. The poll interval, the poll limit and the depth of that chain are all cycle-count parameters.

Top module: `port_quiesce_ctrl`

## Requirements
- R1: After synchronous reset, halt_req_o, done_o and halt_fail_o are all 0.
- R2: When start_i is sampled and the registered idle status is 1, done_o is 1 in the next cycle, halt_fail_o is 0, and halt_req_o never goes high for that operation.
- R3: When start_i is sampled and the registered idle status is 0, halt_req_o rises at that same clock edge and stays high until completion.
- R4: port_idle_i and halt_ack_i each pass through IN_STAGES registers. While the request is pending, the acknowledge is examined only on poll edges, POLL_CYCLES edges apart, with the first poll edge POLL_CYCLES edges after the request edge. Completion (done_o high) comes one edge after the first poll edge that sees the acknowledge.
- R5: If no acknowledge is seen on TIMEOUT_POLLS consecutive poll edges, the controller stops waiting, and done_o comes one edge after the last poll edge, POLL_CYCLES*TIMEOUT_POLLS+1 edges after the request edge.
- R6: At completion of a requested halt, halt_fail_o is the inverse of the registered idle status sampled at the completion edge. This holds whether the wait ended by acknowledge or by timeout.
- R7: halt_req_o is 0 in every cycle in which done_o is 1.
- R8: start_i is ignored while an operation is in progress. It produces no extra done pulse and does not alter the timing of the current one.
- R9: done_o is a one-cycle pulse. halt_fail_o keeps its value from the last completion until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a halt sequence (pulse) |
| port_idle_i | input | 1 | Idle status from the bus port |
| halt_ack_i | input | 1 | Halt acknowledge from the bus port |
| halt_req_o | output | 1 | Halt request to the bus port |
| done_o | output | 1 | One-cycle completion pulse |
| halt_fail_o | output | 1 | Port not idle at completion |

## Verification
The due cycle of each result is counted in edges from the edge that samples start. For an idle port the done pulse is due at 0 edges after that edge. For a request ended by acknowledge it is due at one edge after the first poll edge at or beyond the acknowledge's arrival plus the input register depth. For a timeout it is due at POLL_CYCLES*TIMEOUT_POLLS+1 edges. The driver works out that edge, together with the failure value, from when it raises acknowledge and idle, and pushes them into a queue. The monitor samples 1 ns after every rising edge and compares each done pulse against the head of the queue. Any done pulse with nothing expected counts as a failure, which covers start pulses that should have been ignored.

// File: rtl/pq_pkg.sv
`timescale 1ns/1ps
package pq_pkg;
  typedef enum logic [1:0] {
    PQ_IDLE  = 2'd0,
    PQ_WAIT  = 2'd1,
    PQ_CHECK = 2'd2
  } pq_state_e;
endpackage

// File: rtl/pq_in_reg.sv
`timescale 1ns/1ps
// Register chain for port status inputs before the FSM uses them.
module pq_in_reg #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pq_timer.sv
`timescale 1ns/1ps
// Poll interval counter and poll limit counter.
module pq_timer #(
  parameter int POLL_CYCLES   = 4,
  parameter int TIMEOUT_POLLS = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o,
  output logic final_o
);
  localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam int PW = (TIMEOUT_POLLS > 1) ? $clog2(TIMEOUT_POLLS) : 1;
  localparam logic [CW-1:0] CYC_LAST  = CW'(POLL_CYCLES - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(TIMEOUT_POLLS - 1);

  logic [CW-1:0] cyc_q;
  logic [PW-1:0] poll_q;

  assign tick_o  = run_i && (cyc_q == CYC_LAST);
  assign final_o = (poll_q == POLL_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cyc_q  <= '0;
      poll_q <= '0;
    end else if (tick_o) begin
      cyc_q <= '0;
      if (!final_o) poll_q <= poll_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  generate
    if (POLL_CYCLES > 1) begin : g_tick_chk
      // R4: poll edges are spaced, never back to back
      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pq_fsm.sv
`timescale 1ns/1ps
module pq_fsm
  import pq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic idle_q_i,
  input  logic ack_q_i,
  input  logic tick_i,
  input  logic final_i,
  output logic run_o,
  output logic halt_req_o,
  output logic done_o,
  output logic halt_fail_o
);
  pq_state_e state_q;

  assign run_o = (state_q == PQ_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PQ_IDLE;
      halt_req_o  <= 1'b0;
      done_o      <= 1'b0;
      halt_fail_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        PQ_IDLE: begin
          if (start_i) begin
            if (idle_q_i) begin
              done_o      <= 1'b1;
              halt_fail_o <= 1'b0;
            end else begin
              halt_req_o <= 1'b1;
              state_q    <= PQ_WAIT;
            end
          end
        end
        PQ_WAIT: begin
          if (tick_i && (ack_q_i || final_i)) state_q <= PQ_CHECK;
        end
        PQ_CHECK: begin
          done_o      <= 1'b1;
          halt_fail_o <= !idle_q_i;
          halt_req_o  <= 1'b0;
          state_q     <= PQ_IDLE;
        end
        default: state_q <= PQ_IDLE;
      endcase
    end
  end

  // R2: already-idle port completes next cycle with no request
  a_r2_idle_skip: assert property (@(posedge clk) disable iff (rst)
    (state_q == PQ_IDLE && start_i && idle_q_i) |=> (done_o && !halt_req_o));
  // R3: request held during the wait
  a_r3_req_in_wait: assert property (@(posedge clk) disable iff (rst)
    (state_q == PQ_WAIT) |-> halt_req_o);
  // R4: waiting only ends on a poll edge
  a_r4_exit_on_tick: assert property (@(posedge clk) disable iff (rst)
    (state_q == PQ_WAIT && !tick_i) |=> (state_q == PQ_WAIT));
  // R7: request low when done
  a_r7_req_low_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !halt_req_o);
  // R8: request only rises after a start
  a_r8_req_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_req_o) |-> $past(start_i));
  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9: failure flag changes only at completion
  a_r9_fail_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(halt_fail_o));
endmodule

// File: rtl/port_quiesce_ctrl.sv
`timescale 1ns/1ps
module port_quiesce_ctrl #(
  parameter int POLL_CYCLES   = 4,
  parameter int TIMEOUT_POLLS = 25,
  parameter int IN_STAGES     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic port_idle_i,
  input  logic halt_ack_i,
  output logic halt_req_o,
  output logic done_o,
  output logic halt_fail_o
);
  logic [1:0] stat_q;
  logic       tick, final_poll, run;

  pq_in_reg #(.WIDTH(2), .STAGES(IN_STAGES)) u_in (
    .clk (clk),
    .rst (rst),
    .d_i ({halt_ack_i, port_idle_i}),
    .q_o (stat_q)
  );

  pq_timer #(.POLL_CYCLES(POLL_CYCLES), .TIMEOUT_POLLS(TIMEOUT_POLLS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .tick_o  (tick),
    .final_o (final_poll)
  );

  pq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .idle_q_i    (stat_q[0]),
    .ack_q_i     (stat_q[1]),
    .tick_i      (tick),
    .final_i     (final_poll),
    .run_o       (run),
    .halt_req_o  (halt_req_o),
    .done_o      (done_o),
    .halt_fail_o (halt_fail_o)
  );
endmodule

// File: tb/port_quiesce_ctrl_test.sv
`timescale 1ns/1ps
module port_quiesce_ctrl_test;
  localparam int P = 4;
  localparam int T = 25;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, port_idle_i = 1'b0, halt_ack_i = 1'b0;
  logic halt_req_o, done_o, halt_fail_o;

  port_quiesce_ctrl #(.POLL_CYCLES(P), .TIMEOUT_POLLS(T), .IN_STAGES(S)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .port_idle_i(port_idle_i),
    .halt_ack_i(halt_ack_i), .halt_req_o(halt_req_o), .done_o(done_o),
    .halt_fail_o(halt_fail_o));

  always #2 clk = ~clk;

  typedef struct { int cyc; bit fail; bit skip; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  bit req_seen = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: samples 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      if (!rst) begin
        if (halt_req_o) req_seen = 1'b1;
        if (done_o) begin
          if (q.size() == 0) begin
            check(1'b0, "R8 unexpected done", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(cyc == e.cyc, {e.tag, " done cycle"}, cyc, e.cyc);
            check(halt_fail_o == e.fail, {e.tag, " R6 fail flag"}, int'(halt_fail_o), int'(e.fail));
            check(halt_req_o == 1'b0, "R7 req low at done", int'(halt_req_o), 0);
            check(req_seen == !e.skip, {e.tag, " request raised"}, int'(req_seen), int'(!e.skip));
          end
          req_seen = 1'b0;
        end
      end
    end
  end

  // driver: computes the due cycle and failure value, then plays the stimulus
  task automatic run_op(input bit pre_idle, input int ack_at, input int idle_at,
                        input int extra_start, input string tag);
    exp_t e;
    int n, lat, cs;
    bit idle_seen;
    @(negedge clk);
    port_idle_i = pre_idle;
    halt_ack_i  = 1'b0;
    repeat (S + 3) @(negedge clk);
    if (pre_idle) begin
      lat = 0;
      idle_seen = 1'b1;
    end else begin
      if (ack_at >= 0) begin
        n = (ack_at + S + P - 1) / P;
        if (n < 1) n = 1;
        if (n > T) n = T;
      end else n = T;
      lat = n * P + 1;
      idle_seen = (idle_at >= 0) && (idle_at + S <= lat);
    end
    cs = cyc;
    e.cyc = cs + 1 + lat; e.fail = !idle_seen; e.skip = pre_idle; e.tag = tag;
    q.push_back(e);
    start_i = 1'b1;
    if (ack_at == 0) halt_ack_i = 1'b1;
    if (idle_at == 0) port_idle_i = 1'b1;
    for (int k = 1; k < 400 && q.size() != 0; k++) begin
      @(negedge clk);
      start_i = (k == extra_start);
      if (k == ack_at) halt_ack_i = 1'b1;
      if (k == idle_at) port_idle_i = 1'b1;
      if (k == 1 && !pre_idle)
        check(halt_req_o == 1'b1, "R3 request raised after start", int'(halt_req_o), 1);
    end
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    check(q.size() == 0, {tag, " completion seen"}, q.size(), 0);
    port_idle_i = 1'b0;
    halt_ack_i  = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(halt_req_o == 0, "R1 halt_req reset", int'(halt_req_o), 0);
    check(done_o == 0, "R1 done reset", int'(done_o), 0);
    check(halt_fail_o == 0, "R1 fail reset", int'(halt_fail_o), 0);

    run_op(1'b1, -1, -1, -1, "R2 already idle");
    run_op(1'b0, 5, 5, 3, "R4 ack mid-interval R8 start ignored");
    run_op(1'b0, 10, -1, -1, "R6 ack but not idle");
    // R9 fail flag held between completions
    repeat (10) @(negedge clk);
    check(halt_fail_o == 1'b1, "R9 fail held", int'(halt_fail_o), 1);
    check(done_o == 1'b0, "R9 done low after pulse", int'(done_o), 0);
    run_op(1'b0, 2, 0, -1, "R4 ack reaching first poll");
    run_op(1'b0, 3, 0, -1, "R4 ack missing first poll");
    run_op(1'b0, -1, 20, 50, "R5 timeout idle");
    run_op(1'b0, -1, -1, -1, "R5 timeout not idle");
    run_op(1'b1, 0, -1, -1, "R2 idle with ack present");
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule